// File: doc/BRIEF.md
# Analog Line Sync and Burst Timing Generator

This block produces the horizontal timing of one analog video line from a free-running output pixel clock. A horizontal counter runs from zero to the programmed line length minus one and then wraps. Every output is decoded from that counter and a set of static configuration inputs:

- a sync pulse that starts at count zero;
- a colour-burst gate with a programmable start and a programmable end, where the end value is stored minus 128;
- an active-video window that opens at a programmable blanking end and stays open to the end of the line.

For high-definition component output the block also produces a three-level sync waveform code. The waveform has a low half and a high half, and each edge is ramped over 2 or 4 clocks. A combination of mode inputs gates this waveform. When the combination is not met, the code follows the ordinary bilevel sync. A forwarded copy of the output clock can be divided by two.

The horizontal counter position and the level code are outputs, so downstream DAC logic can select its levels directly.

Top module: `line_timing_gen`

## Requirements
- R1: `hcount` is 0 after reset. It rises by one on each clock and returns to 0 on the clock after it reaches `line_len`-1 (for `line_len` of at least 2).
- R2: `sync_pulse` is 1 exactly while `hcount` < `sync_width`.
- R3: `active_win` is 1 exactly while `hcount` >= `blank_end`. A `blank_end` at or beyond `line_len` keeps it at 0 for the whole line.
- R4: `burst_gate` rises when `hcount` equals `burst_start` and is 1 while `burst_start` <= `hcount` < `burst_end_m128`+128.
- R5: The burst gate closes at `burst_end_m128`+128. If that position lies at or beyond `line_len`, the gate stays open until the counter wraps to 0.
- R6: `tri_mode` is 1 only when `out_mode` = 2'b11, `hd_en` = 1, `raster_sel` is nonzero, `scart_en` = 0 and `tri_dis` = 0.
- R7: When `tri_mode` is 0, `tri_level` is 1 (low) during the sync pulse and 0 (blank) otherwise, and `ramp_step` is 0. A set `scart_en` or `tri_dis` therefore yields bilevel sync.
- R8: When `tri_mode` is 1, with E the edge length and H = `sync_width`/2, the following rules apply in this order of priority:
  - `tri_level` is 3 (ramp) for `hcount` < E;
  - 1 (low) below H;
  - 3 below H+E;
  - 2 (high) below `sync_width`;
  - 3 below `sync_width`+E;
  - 0 (blank) from there on.
- R9: E is 4 when `fast_edge` = 0 and 2 when `fast_edge` = 1. During each ramp, `ramp_step` equals `hcount` minus the start of that ramp: 0, 1, and so on, one per clock.
- R10: With `half_clk` = 0, `clk_fwd` equals `clk_out`. With `half_clk` = 1, it is a register that toggles on every rising edge of `clk_out` and is 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_out | input | 1 | Output pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_len | input | 12 | Output clocks per line |
| sync_width | input | 8 | Sync pulse width in clocks |
| blank_end | input | 10 | Clocks from sync leading edge to active video |
| burst_start | input | 9 | Burst gate start position |
| burst_end_m128 | input | 9 | Burst gate end position minus 128 |
| out_mode | input | 2 | Output mode; 2'b11 permits HD sync |
| hd_en | input | 1 | High-definition output enable |
| raster_sel | input | 2 | Raster select; nonzero permits trilevel sync |
| scart_en | input | 1 | SCART enable; 1 forces bilevel sync |
| tri_dis | input | 1 | Trilevel sync disable |
| fast_edge | input | 1 | Trilevel edge length: 0 gives 4 clocks, 1 gives 2 clocks |
| half_clk | input | 1 | Divide the forwarded clock by two |
| hcount | output | 12 | Horizontal position |
| sync_pulse | output | 1 | Bilevel sync pulse |
| burst_gate | output | 1 | Colour-burst gate |
| active_win | output | 1 | Active-video window |
| tri_mode | output | 1 | Trilevel sync in effect |
| tri_level | output | 2 | Sync level code: 0 blank, 1 low, 2 high, 3 ramp |
| ramp_step | output | 2 | Position within the current ramp |
| clk_fwd | output | 1 | Forwarded clock |

## Verification
Every timing output is decoded from the single horizontal counter, so a counter that skips a value or wraps at the wrong count shifts every window. The error shows on `hcount` and on the sync, burst and active edges in the very cycle it occurs, and again on each following line. A wrong ramp-phase decode or a wrong mode gate shows within the first few clocks of a line as a wrong `tri_level` or `ramp_step` code. The bench therefore compares every output on every clock of at least two full lines, across configurations that each isolate one mode condition.

// File: rtl/line_timing_gen.sv
module line_timing_gen #(
  parameter int CW   = 12,
  parameter int SW   = 8,
  parameter int BW   = 10,
  parameter int GW   = 9,
  parameter int GOFS = 128
) (
  input  logic          clk_out,
  input  logic          rst_n,
  input  logic [CW-1:0] line_len,
  input  logic [SW-1:0] sync_width,
  input  logic [BW-1:0] blank_end,
  input  logic [GW-1:0] burst_start,
  input  logic [GW-1:0] burst_end_m128,
  input  logic [1:0]    out_mode,
  input  logic          hd_en,
  input  logic [1:0]    raster_sel,
  input  logic          scart_en,
  input  logic          tri_dis,
  input  logic          fast_edge,
  input  logic          half_clk,
  output logic [CW-1:0] hcount,
  output logic          sync_pulse,
  output logic          burst_gate,
  output logic          active_win,
  output logic          tri_mode,
  output logic [1:0]    tri_level,
  output logic [1:0]    ramp_step,
  output logic          clk_fwd
);

  localparam logic [1:0] LV_BLANK = 2'd0;
  localparam logic [1:0] LV_LOW   = 2'd1;
  localparam logic [1:0] LV_HIGH  = 2'd2;
  localparam logic [1:0] LV_RAMP  = 2'd3;

  logic [CW-1:0] h;
  logic          div_q;
  logic          chk_arm;

  always_ff @(posedge clk_out or negedge rst_n)
    if (!rst_n) h <= '0;
    else        h <= (h >= line_len - CW'(1)) ? '0 : h + CW'(1);

  always_ff @(posedge clk_out or negedge rst_n)
    if (!rst_n) div_q <= 1'b0;
    else        div_q <= ~div_q;

  always_ff @(posedge clk_out or negedge rst_n)
    if (!rst_n) chk_arm <= 1'b0;
    else        chk_arm <= 1'b1;

  wire [CW-1:0] sw_w      = CW'(sync_width);
  wire [CW-1:0] half_w    = CW'(sync_width >> 1);
  wire [CW-1:0] burst_on  = CW'(burst_start);
  wire [CW-1:0] burst_off = CW'(burst_end_m128) + CW'(GOFS);
  wire [CW-1:0] edge_len  = fast_edge ? CW'(2) : CW'(4);

  assign hcount     = h;
  assign sync_pulse = h < sw_w;
  assign active_win = h >= CW'(blank_end);
  assign burst_gate = (h >= burst_on) && (h < burst_off);
  assign tri_mode   = (out_mode == 2'b11) && hd_en && (raster_sel != 2'b00)
                      && !scart_en && !tri_dis;
  assign clk_fwd    = half_clk ? div_q : clk_out;

  logic [CW-1:0] ofs;
  always_comb begin
    ofs       = '0;
    tri_level = LV_BLANK;
    if (!tri_mode) begin
      tri_level = sync_pulse ? LV_LOW : LV_BLANK;
    end else if (h < edge_len) begin
      tri_level = LV_RAMP;
      ofs       = h;
    end else if (h < half_w) begin
      tri_level = LV_LOW;
    end else if (h < half_w + edge_len) begin
      tri_level = LV_RAMP;
      ofs       = h - half_w;
    end else if (h < sw_w) begin
      tri_level = LV_HIGH;
    end else if (h < sw_w + edge_len) begin
      tri_level = LV_RAMP;
      ofs       = h - sw_w;
    end
  end
  assign ramp_step = ofs[1:0];

  // R1
  hcount_wrap_chk: assert property (@(posedge clk_out) disable iff (!rst_n)
    (chk_arm && $past(h) == line_len - CW'(1)) |-> (h == '0));
  // R1
  hcount_step_chk: assert property (@(posedge clk_out) disable iff (!rst_n)
    (chk_arm && $past(h) < line_len - CW'(1)) |-> (h == $past(h) + CW'(1)));
  // R2
  sync_fall_chk: assert property (@(posedge clk_out) disable iff (!rst_n)
    (chk_arm && $fell(sync_pulse)) |-> (h == sw_w));
  // R4
  burst_rise_chk: assert property (@(posedge clk_out) disable iff (!rst_n)
    (chk_arm && $rose(burst_gate)) |-> (h == burst_on));
  // R5
  burst_fall_chk: assert property (@(posedge clk_out) disable iff (!rst_n)
    (chk_arm && $fell(burst_gate)) |-> (h == burst_off || h == '0));
  // R9
  ramp_range_chk: assert property (@(posedge clk_out) disable iff (!rst_n)
    (tri_level != LV_RAMP) |-> (ramp_step == 2'd0));
  // R10
  clk_half_chk: assert property (@(posedge clk_out) disable iff (!rst_n)
    (chk_arm && half_clk && $past(half_clk)) |-> (clk_fwd != $past(clk_fwd)));

endmodule

// File: tb/line_timing_gen_tb.sv
module line_timing_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] line_len = 12'd300;
  logic [7:0]  sync_width = 8'd20;
  logic [9:0]  blank_end = 10'd60;
  logic [8:0]  burst_start = 9'd25, burst_end_m128 = 9'd10;
  logic [1:0]  out_mode = 2'b00, raster_sel = 2'b00;
  logic hd_en = 0, scart_en = 0, tri_dis = 0, fast_edge = 0, half_clk = 0;
  logic [11:0] hcount;
  logic sync_pulse, burst_gate, active_win, tri_mode, clk_fwd;
  logic [1:0] tri_level, ramp_step;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_timing_gen dut_i (
    .clk_out(clk), .rst_n(rst_n), .line_len(line_len), .sync_width(sync_width),
    .blank_end(blank_end), .burst_start(burst_start), .burst_end_m128(burst_end_m128),
    .out_mode(out_mode), .hd_en(hd_en), .raster_sel(raster_sel), .scart_en(scart_en),
    .tri_dis(tri_dis), .fast_edge(fast_edge), .half_clk(half_clk),
    .hcount(hcount), .sync_pulse(sync_pulse), .burst_gate(burst_gate),
    .active_win(active_win), .tri_mode(tri_mode), .tri_level(tri_level),
    .ramp_step(ramp_step), .clk_fwd(clk_fwd));

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_cfg(int cycles);
    int eh = 0;
    int e, hh, w, lvl, st, bend;
    bit etm, prev_cf;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset", int'(hcount), 0);
    prev_cf = clk_fwd;
    for (int c = 0; c < cycles; c++) begin
      if (c > 0) begin
        @(negedge clk);
        eh = (eh >= int'(line_len) - 1) ? 0 : eh + 1;
        if (half_clk) chk("R10 toggle", int'(clk_fwd), int'(!prev_cf));
        else          chk("R10 pass", int'(clk_fwd), 0);
        prev_cf = clk_fwd;
      end
      w    = int'(sync_width);
      hh   = w / 2;
      e    = fast_edge ? 2 : 4;
      bend = int'(burst_end_m128) + 128;
      etm  = (out_mode == 2'b11) && hd_en && (raster_sel != 0) && !scart_en && !tri_dis;
      chk("R1 hcount", int'(hcount), eh);
      chk("R2 sync", int'(sync_pulse), int'(eh < w));
      chk("R3 active", int'(active_win), int'(eh >= int'(blank_end)));
      chk("R4 R5 burst", int'(burst_gate), int'(eh >= int'(burst_start) && eh < bend));
      chk("R6 mode", int'(tri_mode), int'(etm));
      st = 0;
      if (!etm)               lvl = (eh < w) ? 1 : 0;
      else if (eh < e)        begin lvl = 3; st = eh; end
      else if (eh < hh)       lvl = 1;
      else if (eh < hh + e)   begin lvl = 3; st = eh - hh; end
      else if (eh < w)        lvl = 2;
      else if (eh < w + e)    begin lvl = 3; st = eh - w; end
      else                    lvl = 0;
      chk(etm ? "R8 level" : "R7 level", int'(tri_level), lvl);
      chk("R9 step", int'(ramp_step), st);
    end
  endtask

  initial begin
    // bilevel, burst end inside the line
    run_cfg(2 * 300 + 5);
    // trilevel, fast edges, burst end beyond line, half clock
    line_len = 12'd200; sync_width = 8'd40; burst_end_m128 = 9'd100;
    out_mode = 2'b11; hd_en = 1; raster_sel = 2'b01; fast_edge = 1; half_clk = 1;
    run_cfg(2 * 200 + 5);
    // trilevel, slow edges, odd width
    sync_width = 8'd33; fast_edge = 0; raster_sel = 2'b10; burst_start = 9'd0;
    run_cfg(2 * 200 + 5);
    // SCART forces bilevel
    scart_en = 1; half_clk = 0;
    run_cfg(210);
    // disable bit forces bilevel
    scart_en = 0; tri_dis = 1;
    run_cfg(210);
    // zero raster select
    tri_dis = 0; raster_sel = 2'b00;
    run_cfg(210);
    // wrong output mode, blank end beyond line
    raster_sel = 2'b11; out_mode = 2'b10; blank_end = 10'd500;
    run_cfg(210);
    // HD enable cleared
    out_mode = 2'b11; hd_en = 0;
    run_cfg(210);
    // short line
    hd_en = 1; line_len = 12'd2; sync_width = 8'd1; blank_end = 10'd1; half_clk = 1;
    run_cfg(9);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule